// File: doc/BRIEF.md
# CPU Reset and Interrupt Vector Sequencer

This block is the control unit that moves a 16-bit 6502-family CPU core into a handler. It reacts to an architectural reset request, a non-maskable interrupt, a maskable interrupt and the software exceptions that the decoder raises. The software exceptions are the coprocessor trap, the break instruction and the abort. For each event it works out a bank-0 vector address from the event kind and from the emulation/native mode. It then reads the two handler bytes over a simple synchronous byte-read port and loads the program counter.

On a reset request it also puts the mode flags and the stack pointer back to their start-up values. It clears the wait and stop latches. The instruction side sets those latches when it executes the wait-for-interrupt and stop instructions. A free-running count of accepted bus reads is kept for timing accounting. Only the hardware reset pin clears that count. A reset request does not.

Top module: `irq_vector_seq`

## Requirements
- R1: In native mode (flags bit 4 = 0), the vector addresses are $FFE4 for the coprocessor trap, $FFE6 for break, $FFE8 for abort, $FFEA for NMI and $FFEE for IRQ. Every vector read drives zero on `bus_addr[23:16]`.
- R2: In emulation mode (flags bit 4 = 1), the vector addresses are $FFF4 for the coprocessor trap, $FFF8 for abort and $FFFA for NMI. IRQ and break share $FFFE.
- R3: A reset request always reads from $FFFC, whichever mode was active. Every completed vector load leaves `pbr` at 0.
- R4: A fetch makes exactly two accepted reads (`bus_rd` and `bus_ready` both high). The low byte comes from the vector address and the high byte from vector+1. Cycles without `bus_ready` only stall the fetch. `vec_done` is high for one cycle, in the cycle after the second accepted read. `pc` = {high, low} from the following cycle.
- R5: In the cycle after `reset_req`, `flags` = {E,M,X,I,D} (bits 4..0) = 5'b11110 and `sp` = $01FF. A flag or stack-pointer write in the same cycle is overridden.
- R6: A reset request clears both `waiting` and `stopped`.
- R7: A `wai_set` pulse sets `waiting`. It stays set until an NMI or an IRQ arrives. An IRQ that arrives while I=1 (flags bit 1) still clears `waiting`, but it starts no fetch.
- R8: While `stopped` is set, NMI, IRQ and software requests start no bus reads. Only `reset_req` leaves that state.
- R9: `cycle_cnt` adds one for each accepted read. A reset request does not clear it. Only `rst_n` low does.
- R10: When several requests arrive together, reset wins over NMI, NMI wins over IRQ, and IRQ wins over software requests. IRQ is taken only while I=0.
- R11: `sw_kind` encodes 2'b00 as the coprocessor trap, 2'b01 as break, and 2'b10 or 2'b11 as abort. A software request is ignored while `waiting` is set.
- R12: After `rst_n` low, `pc`, `pbr` and `cycle_cnt` are 0, `flags` = 5'b11110, `sp` = $01FF, and both latches are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reset_req | input | 1 | Architectural reset request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| sw_req | input | 1 | Software exception request from the decoder |
| sw_kind | input | 2 | Software exception kind (see R11) |
| wai_set | input | 1 | Set the wait latch |
| stp_set | input | 1 | Set the stop latch |
| flags_wr | input | 1 | Load flags from flags_in |
| flags_in | input | 5 | New {E,M,X,I,D} |
| sp_wr | input | 1 | Load sp from sp_in |
| sp_in | input | 16 | New stack pointer |
| pc_wr | input | 1 | Load {pbr,pc} from pc_in |
| pc_in | input | 24 | New bank and program counter |
| bus_addr | output | 24 | Read address |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Read accepted this cycle |
| vec_done | output | 1 | One-cycle vector-load completion pulse |
| pc | output | 16 | Program counter |
| pbr | output | 8 | Program bank |
| flags | output | 5 | {E,M,X,I,D} |
| sp | output | 16 | Stack pointer |
| waiting | output | 1 | Wait latch |
| stopped | output | 1 | Stop latch |
| cycle_cnt | output | 32 | Accepted-read count |

## Verification
The bench walks every event kind in both modes. It looks for a design that mixes up the two vector tables, that sends break to its native slot while in emulation mode, or that takes the reset vector from the current mode. It fires requests at the same time to expose a wrong priority order. It checks that an IRQ arriving while I=1 clears the wait latch but does not fetch, which catches a design that either stays asleep or jumps anyway. It drives NMI and IRQ into the stopped state and checks that they are ignored. Further cases cover a reset request in native mode, which must not clear the read count but must force the flags and the stack pointer, and a fetch under read stalls, where the count must still grow by exactly two and the high-byte address must still be vector+1.

// File: rtl/ivs_pkg.sv
// Shared types for the vector sequencer.
// Assumes: flags are ordered {E,M,X,I,D} from MSB to LSB.
package ivs_pkg;
    typedef enum logic [2:0] {
        EV_NONE, EV_RESET, EV_NMI, EV_IRQ, EV_COP, EV_BRK, EV_ABORT
    } event_t;

    typedef struct packed {
        logic emu;
        logic m;
        logic x;
        logic i;
        logic d;
    } mode_flags_t;

    localparam mode_flags_t RESET_FLAGS = '{emu: 1'b1, m: 1'b1, x: 1'b1, i: 1'b1, d: 1'b0};
    localparam logic [15:0] RESET_SP    = 16'h01FF;
endpackage

// File: rtl/ivs_vector_map.sv
// Maps an accepted event and the current mode to its bank-0 vector word.
// Assumes: the reset event ignores the mode; EV_NONE never reaches a fetch.
module ivs_vector_map
    import ivs_pkg::*;
(
    input  event_t      evt,
    input  logic        emu,
    output logic [15:0] vec
);
    // Pick the vector from the event kind and the mode table.
    always_comb begin
        unique case (evt)
            EV_RESET: vec = 16'hFFFC;
            EV_NMI:   vec = emu ? 16'hFFFA : 16'hFFEA;
            EV_IRQ:   vec = emu ? 16'hFFFE : 16'hFFEE;
            EV_COP:   vec = emu ? 16'hFFF4 : 16'hFFE4;
            EV_BRK:   vec = emu ? 16'hFFFE : 16'hFFE6;
            EV_ABORT: vec = emu ? 16'hFFF8 : 16'hFFE8;
            default:  vec = 16'hFFFC;
        endcase
    end
endmodule

// File: rtl/ivs_fetch.sv
// Two-byte vector fetch engine plus the accepted-read counter.
// Assumes: a start while busy restarts the fetch (the arbiter only does
// that for reset); a read is accepted when bus_rd and bus_ready are both high.
module ivs_fetch #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       vec,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready,
    output logic              idle,
    output logic              done,
    output logic [15:0]       target,
    output logic [CNT_W-1:0]  cycle_cnt
);
    localparam int PAD_W = ADDR_W - 16;

    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI, F_FIN} fstate_t;

    fstate_t     state;
    logic [15:0] vaddr;
    logic [7:0]  lo_q, hi_q;
    logic        accept;

    assign accept = bus_rd && bus_ready;

    // Sequence: low byte, high byte, then one completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
            vaddr <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (start) begin
            state <= F_LO;
            vaddr <= vec;
        end else begin
            unique case (state)
                F_LO: if (bus_ready) begin
                    lo_q  <= bus_rdata;
                    state <= F_HI;
                end
                F_HI: if (bus_ready) begin
                    hi_q  <= bus_rdata;
                    state <= F_FIN;
                end
                F_FIN:   state <= F_IDLE;
                default: state <= F_IDLE;
            endcase
        end
    end

    // Count every accepted byte read; only the hardware reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cycle_cnt <= '0;
        else if (accept)
            cycle_cnt <= cycle_cnt + 1'b1;
    end

    assign bus_rd   = (state == F_LO) || (state == F_HI);
    assign bus_addr = {{PAD_W{1'b0}}, (state == F_HI) ? vaddr + 16'd1 : vaddr};
    assign idle     = (state == F_IDLE);
    assign done     = (state == F_FIN);
    assign target   = {hi_q, lo_q};
endmodule

// File: rtl/ivs_arch_state.sv
// Architectural registers touched by the sequencer: PC, bank, flags,
// stack pointer and the wait/stop latches.
// Assumes: a reset request wins over the instruction-side writes in the same cycle.
module ivs_arch_state
    import ivs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        do_reset,
    input  logic        done,
    input  logic [15:0] target,
    input  logic        clr_wait,
    input  logic        wai_set,
    input  logic        stp_set,
    input  logic        flags_wr,
    input  mode_flags_t flags_in,
    input  logic        sp_wr,
    input  logic [15:0] sp_in,
    input  logic        pc_wr,
    input  logic [23:0] pc_in,
    output logic [15:0] pc,
    output logic [7:0]  pbr,
    output mode_flags_t flags,
    output logic [15:0] sp,
    output logic        waiting,
    output logic        stopped
);
    // Mode flags: forced on reset, otherwise written by the instruction side.
    always_ff @(posedge clk) begin
        if (!rst_n || do_reset) flags <= RESET_FLAGS;
        else if (flags_wr)      flags <= flags_in;
    end

    // Stack pointer: parked at its start value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || do_reset) sp <= RESET_SP;
        else if (sp_wr)         sp <= sp_in;
    end

    // Program counter and bank: a vector load takes precedence over a jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            pbr <= '0;
        end else if (done) begin
            pc  <= target;
            pbr <= '0;
        end else if (do_reset) begin
            pbr <= '0;
        end else if (pc_wr) begin
            pc  <= pc_in[15:0];
            pbr <= pc_in[23:16];
        end
    end

    // Wait latch: set by the decoder, cleared by any interrupt or by reset.
    always_ff @(posedge clk) begin
        if (!rst_n || do_reset) waiting <= 1'b0;
        else if (clr_wait)      waiting <= 1'b0;
        else if (wai_set)       waiting <= 1'b1;
    end

    // Stop latch: only a reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || do_reset) stopped <= 1'b0;
        else if (stp_set)       stopped <= 1'b1;
    end
endmodule

// File: rtl/irq_vector_seq.sv
// Top of the reset/interrupt vector sequencer. It arbitrates requests,
// selects the vector and runs the two-byte fetch.
// Assumes: requests are levels sampled each cycle; non-reset events are
// accepted only when the fetch engine is idle.
module irq_vector_seq
    import ivs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic              sw_req,
    input  logic [1:0]        sw_kind,
    input  logic              wai_set,
    input  logic              stp_set,
    input  logic              flags_wr,
    input  logic [4:0]        flags_in,
    input  logic              sp_wr,
    input  logic [15:0]       sp_in,
    input  logic              pc_wr,
    input  logic [23:0]       pc_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready,
    output logic              vec_done,
    output logic [15:0]       pc,
    output logic [7:0]        pbr,
    output logic [4:0]        flags,
    output logic [15:0]       sp,
    output logic              waiting,
    output logic              stopped,
    output logic [CNT_W-1:0]  cycle_cnt
);
    event_t      evt;
    logic        clr_wait;
    logic        eng_idle;
    logic [15:0] vec;
    logic [15:0] target;
    mode_flags_t flags_q;

    // Priority arbiter: reset, NMI, unmasked IRQ, then software exceptions.
    always_comb begin
        evt = EV_NONE;
        if (reset_req) begin
            evt = EV_RESET;
        end else if (!stopped && eng_idle) begin
            if (nmi_req)
                evt = EV_NMI;
            else if (irq_req && !flags_q.i)
                evt = EV_IRQ;
            else if (sw_req && !waiting) begin
                unique case (sw_kind)
                    2'b00:   evt = EV_COP;
                    2'b01:   evt = EV_BRK;
                    default: evt = EV_ABORT;
                endcase
            end
        end
    end

    // Any interrupt clears the wait latch, including an IRQ that is masked.
    always_comb begin
        clr_wait = (evt == EV_NMI) || (evt == EV_IRQ) || (irq_req && !stopped);
    end

    ivs_vector_map u_map (
        .evt (evt),
        .emu (flags_q.emu),
        .vec (vec)
    );

    ivs_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (evt != EV_NONE),
        .vec       (vec),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .idle      (eng_idle),
        .done      (vec_done),
        .target    (target),
        .cycle_cnt (cycle_cnt)
    );

    ivs_arch_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_reset (reset_req),
        .done     (vec_done),
        .target   (target),
        .clr_wait (clr_wait),
        .wai_set  (wai_set),
        .stp_set  (stp_set),
        .flags_wr (flags_wr),
        .flags_in (mode_flags_t'(flags_in)),
        .sp_wr    (sp_wr),
        .sp_in    (sp_in),
        .pc_wr    (pc_wr),
        .pc_in    (pc_in),
        .pc       (pc),
        .pbr      (pbr),
        .flags    (flags_q),
        .sp       (sp),
        .waiting  (waiting),
        .stopped  (stopped)
    );

    assign flags = flags_q;
endmodule

// File: rtl/irq_vector_seq_chk.sv
// Property checker bound to the sequencer top; it watches ports only.
module irq_vector_seq_chk #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reset_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_ready,
    input logic              vec_done,
    input logic [7:0]        pbr,
    input logic [4:0]        flags,
    input logic [15:0]       sp,
    input logic              waiting,
    input logic              stopped,
    input logic [CNT_W-1:0]  cycle_cnt
);
    assert_bank0_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr[ADDR_W-1:16] == '0));

    assert_bank_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |=> (pbr == 8'h00));

    assert_done_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |-> $past(bus_rd && bus_ready));

    assert_reset_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (flags == 5'b11110 && sp == 16'h01FF));

    assert_reset_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (!waiting && !stopped));

    assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !bus_rd && !reset_req) |=> !bus_rd);

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_ready) |=> $stable(cycle_cnt));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ready) |=> (cycle_cnt != $past(cycle_cnt)));
endmodule

bind irq_vector_seq irq_vector_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_req (reset_req),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_ready (bus_ready),
    .vec_done  (vec_done),
    .pbr       (pbr),
    .flags     (flags),
    .sp        (sp),
    .waiting   (waiting),
    .stopped   (stopped),
    .cycle_cnt (cycle_cnt)
);

// File: tb/irq_vector_seq_tb_top.sv
module irq_vector_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    // Row: {event code[2:0], emu, vector[15:0]}; codes 0 reset,1 nmi,2 irq,3 cop,4 brk,5 abort
    localparam int NROWS = 12;
    localparam logic [19:0] VEC_TABLE [NROWS] = '{
        {3'd3, 1'b0, 16'hFFE4}, {3'd4, 1'b0, 16'hFFE6}, {3'd5, 1'b0, 16'hFFE8},
        {3'd1, 1'b0, 16'hFFEA}, {3'd2, 1'b0, 16'hFFEE},
        {3'd3, 1'b1, 16'hFFF4}, {3'd4, 1'b1, 16'hFFFE}, {3'd5, 1'b1, 16'hFFF8},
        {3'd1, 1'b1, 16'hFFFA}, {3'd2, 1'b1, 16'hFFFE},
        {3'd0, 1'b0, 16'hFFFC}, {3'd0, 1'b1, 16'hFFFC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 0, nmi_req = 0, irq_req = 0, sw_req = 0;
    logic [1:0]  sw_kind = 0;
    logic        wai_set = 0, stp_set = 0, flags_wr = 0, sp_wr = 0, pc_wr = 0;
    logic [4:0]  flags_in = 0;
    logic [15:0] sp_in = 0;
    logic [23:0] pc_in = 0;
    logic [23:0] bus_addr;
    logic        bus_rd, bus_ready, vec_done, waiting, stopped;
    logic [7:0]  bus_rdata, pbr;
    logic [15:0] pc, sp;
    logic [4:0]  flags;
    logic [31:0] cycle_cnt;
    logic        stall_en = 1'b0;
    logic        ready_pat = 1'b0;
    logic [23:0] prev_addr = 0, last_addr = 0;
    logic [31:0] cnt_before = 0;
    int          n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) ready_pat <= ~ready_pat;
    assign bus_ready = stall_en ? ready_pat : 1'b1;
    assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

    // Record the addresses of the last two accepted reads.
    always @(negedge clk) if (bus_rd && bus_ready) begin
        prev_addr <= last_addr;
        last_addr <= bus_addr;
    end

    irq_vector_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .sw_req(sw_req), .sw_kind(sw_kind), .wai_set(wai_set),
        .stp_set(stp_set), .flags_wr(flags_wr), .flags_in(flags_in), .sp_wr(sp_wr),
        .sp_in(sp_in), .pc_wr(pc_wr), .pc_in(pc_in), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .vec_done(vec_done), .pc(pc), .pbr(pbr), .flags(flags), .sp(sp),
        .waiting(waiting), .stopped(stopped), .cycle_cnt(cycle_cnt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Set mode flags {emu,1,1,i,0} and a nonzero bank/PC.
    task automatic setup(input logic emu, input logic ival);
        @(negedge clk);
        flags_wr = 1; flags_in = {emu, 1'b1, 1'b1, ival, 1'b0};
        pc_wr = 1; pc_in = 24'h7F1234;
        @(negedge clk);
        flags_wr = 0; pc_wr = 0;
    endtask

    // Drive a request pattern for one cycle.
    task automatic fire(input logic r, input logic n, input logic q,
                        input logic s, input logic [1:0] k);
        @(negedge clk);
        cnt_before = cycle_cnt;
        reset_req = r; nmi_req = n; irq_req = q; sw_req = s; sw_kind = k;
        @(negedge clk);
        reset_req = 0; nmi_req = 0; irq_req = 0; sw_req = 0; sw_kind = 0;
    endtask

    task automatic fire_code(input logic [2:0] code);
        case (code)
            3'd0: fire(1, 0, 0, 0, 2'b00);
            3'd1: fire(0, 1, 0, 0, 2'b00);
            3'd2: fire(0, 0, 1, 0, 2'b00);
            3'd3: fire(0, 0, 0, 1, 2'b00);
            3'd4: fire(0, 0, 0, 1, 2'b01);
            default: fire(0, 0, 0, 1, 2'b10);
        endcase
    endtask

    // Wait for completion and check PC, bank, read order and count.
    task automatic expect_fetch(input logic [15:0] v, input string req);
        logic [15:0] v1;
        bit seen;
        v1 = v + 16'd1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (vec_done) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen, req, "vec_done seen", {31'd0, seen}, 32'd1);
        @(negedge clk);
        check(pc == {v1[7:0] ^ 8'hA5, v[7:0] ^ 8'hA5}, req, "pc",
              {16'd0, pc}, {16'd0, v1[7:0] ^ 8'hA5, v[7:0] ^ 8'hA5});
        check(pbr == 8'h00, {req, " R3"}, "pbr", {24'd0, pbr}, 32'd0);
        check(prev_addr == {8'h00, v} && last_addr == {8'h00, v1}, {req, " R4"},
              "read order", {8'd0, last_addr}, {8'd0, 8'h00, v1});
        check(cycle_cnt == cnt_before + 2, {req, " R9"}, "count delta",
              cycle_cnt - cnt_before, 32'd2);
    endtask

    task automatic expect_no_fetch(input string req);
        repeat (6) @(negedge clk);
        check(cycle_cnt == cnt_before, req, "no reads", cycle_cnt, cnt_before);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: hardware reset state
        check(pc == 0 && pbr == 0, "R12", "pc/pbr", {8'd0, pbr, pc}, 32'd0);
        check(cycle_cnt == 0, "R12", "count", cycle_cnt, 32'd0);
        check(flags == 5'b11110 && sp == 16'h01FF, "R12", "flags/sp",
              {11'd0, flags, sp}, {11'd0, 5'b11110, 16'h01FF});
        check(!waiting && !stopped, "R12", "latches", {30'd0, waiting, stopped}, 32'd0);

        // R1 R2 R3 R11: vector table walk
        for (int row = 0; row < NROWS; row++) begin
            setup(VEC_TABLE[row][16], 1'b0);
            fire_code(VEC_TABLE[row][19:17]);
            expect_fetch(VEC_TABLE[row][15:0], VEC_TABLE[row][16] ? "R2/R11" : "R1/R11");
        end

        // R5 R9: reset from native mode with altered flags and stack pointer
        @(negedge clk);
        flags_wr = 1; flags_in = 5'b00001; sp_wr = 1; sp_in = 16'h1234;
        @(negedge clk);
        flags_wr = 0; sp_wr = 0;
        fire(1, 0, 0, 0, 2'b00);
        check(flags == 5'b11110, "R5", "flags", {27'd0, flags}, {27'd0, 5'b11110});
        check(sp == 16'h01FF, "R5", "sp", {16'd0, sp}, 32'h01FF);
        check(cycle_cnt >= 2, "R9", "count kept over reset", cycle_cnt, 32'd2);
        expect_fetch(16'hFFFC, "R3/R5");

        // R7 R11: wait latch, ignored software request, masked IRQ
        setup(1'b0, 1'b1);
        @(negedge clk); wai_set = 1;
        @(negedge clk); wai_set = 0;
        check(waiting, "R7", "waiting set", {31'd0, waiting}, 32'd1);
        fire(0, 0, 0, 1, 2'b01);
        expect_no_fetch("R11 sw while waiting");
        fire(0, 0, 1, 0, 2'b00);
        check(!waiting, "R7", "masked irq wakes", {31'd0, waiting}, 32'd0);
        expect_no_fetch("R7 masked irq");

        // R7: NMI wakes and fetches
        @(negedge clk); wai_set = 1;
        @(negedge clk); wai_set = 0;
        fire(0, 1, 0, 0, 2'b00);
        check(!waiting, "R7", "nmi wakes", {31'd0, waiting}, 32'd0);
        expect_fetch(16'hFFEA, "R7");

        // R8 R6: stop state ignores interrupts until reset
        setup(1'b0, 1'b0);
        @(negedge clk); stp_set = 1;
        @(negedge clk); stp_set = 0;
        check(stopped, "R8", "stopped set", {31'd0, stopped}, 32'd1);
        fire(0, 1, 0, 0, 2'b00);
        expect_no_fetch("R8 nmi");
        fire(0, 0, 1, 0, 2'b00);
        expect_no_fetch("R8 irq");
        check(stopped, "R8", "still stopped", {31'd0, stopped}, 32'd1);
        fire(1, 0, 0, 0, 2'b00);
        check(!stopped, "R6", "stop cleared", {31'd0, stopped}, 32'd0);
        expect_fetch(16'hFFFC, "R6/R8");

        // R10: simultaneous requests
        setup(1'b0, 1'b0);
        fire(0, 1, 1, 0, 2'b00);
        expect_fetch(16'hFFEA, "R10 nmi>irq");
        setup(1'b0, 1'b0);
        fire(0, 0, 1, 1, 2'b00);
        expect_fetch(16'hFFEE, "R10 irq>sw");
        setup(1'b0, 1'b0);
        fire(1, 1, 0, 0, 2'b00);
        expect_fetch(16'hFFFC, "R10 reset>nmi");
        setup(1'b0, 1'b1);
        fire(0, 0, 1, 0, 2'b00);
        expect_no_fetch("R10 irq masked");

        // R4: fetch under read stalls
        setup(1'b1, 1'b0);
        @(negedge clk); stall_en = 1;
        fire(0, 1, 0, 0, 2'b00);
        expect_fetch(16'hFFFA, "R4 stall");
        stall_en = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule